// File: doc/BRIEF.md
# Programmable Two-Digit Combination Lock

This block is a clocked state machine that drives a door latch. A user dials a two-bit value on the code input and presses the Enter button once for each of two digits. When both digits equal the stored combination, in order, the latch opens. A wrong entry is reported only after the second digit, so a mistake in the first digit gives nothing away. A further press while open starts a two-step programming sequence. The value dialled at each of the next two presses becomes the new first and second digit, and the lock then returns to the open state.

The Enter button is treated as a level. An internal rising-edge detector turns each press into one step, however long the button is held. A separate combination-reset control restores the default pair. The ordinary synchronous reset only returns the machine to waiting for the first digit. The outputs are Moore outputs, decoded from the current state alone: a latch drive, four indicators and a three-bit view of the state.

The states are WAIT_D1 (waiting for the first digit), WAIT_D2 (first digit correct), WAIT_D2_BAD (first digit wrong), OPEN, PROG1, PROG2 and ERROR. Every transition is taken on an Enter press:
- WAIT_D1 goes to WAIT_D2 on a matching code and to WAIT_D2_BAD otherwise.
- WAIT_D2 goes to OPEN on a matching code and to ERROR otherwise.
- WAIT_D2_BAD always goes to ERROR.
- ERROR goes to WAIT_D1.
- OPEN goes to PROG1.
- PROG1 stores the first digit and goes to PROG2.
- PROG2 stores the second digit and goes to OPEN.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the machine goes to WAIT_D1 (`state_dbg` = 0) with all outputs low, and the stored combination is left unchanged.
- R2: When `combo_reset` is high at a clock edge, the stored combination becomes first digit 2'b11 and second digit 2'b01. This takes priority over a programming write in the same cycle.
- R3: Each low-to-high transition of `enter_btn` advances the machine by exactly one transition, however many cycles the button stays high. The new state is visible two clock edges after the rising edge is sampled.
- R4: Entering the stored first digit and then the stored second digit reaches OPEN, with `open_o` and `led_open` high.
- R5: A wrong first digit leads to WAIT_D2_BAD with `led_error` low. The second press then leads to ERROR with `led_error` high, whatever code is given.
- R6: A correct first digit followed by a wrong second digit leads to ERROR.
- R7: An Enter press in ERROR returns the machine to WAIT_D1 and clears `led_error`.
- R8: An Enter press in OPEN leads to PROG1 with `led_prog1` high and `open_o` low.
- R9: The code at the press in PROG1 becomes the new first digit, and the machine goes to PROG2 with `led_prog2` high and `open_o` low. The code at the press in PROG2 becomes the new second digit, and the machine goes back to OPEN. From then on only the new pair opens the lock.
- R10: `state_dbg` encodes the states as WAIT_D1=0, WAIT_D2=1, WAIT_D2_BAD=2, OPEN=3, PROG1=4, PROG2=5, ERROR=6.
- R11: Without an Enter press, changing `code_in` changes neither the state nor any output. At most one of the four indicators is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the state machine |
| code_in | input | 2 | Dialled digit |
| enter_btn | input | 1 | Enter button level |
| combo_reset | input | 1 | Reload the default combination |
| open_o | output | 1 | Latch drive, high only in OPEN |
| led_open | output | 1 | Open indicator |
| led_prog1 | output | 1 | Programming first-digit indicator |
| led_prog2 | output | 1 | Programming second-digit indicator |
| led_error | output | 1 | Error indicator |
| state_dbg | output | 3 | Current state code |

## Verification
Random presses are made with random codes. About half of them dial the digit the reference model expects, so that the open and programming paths are reached often, alongside the wrong-first-digit and wrong-second-digit paths. Directed sequences cover a default unlock followed by reprogramming to a new pair. They then show that the old pair fails and the new pair succeeds. A long button hold separates a true edge detector from a level-sensitive one. Changes to `code_in` without any press, and reset or combination-reset applied between sequences, show that nothing else moves the state or the stored digits.

// File: rtl/lock_pkg.sv
package lock_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_D1     = 3'd0,
        ST_WAIT_D2     = 3'd1,
        ST_WAIT_D2_BAD = 3'd2,
        ST_OPEN        = 3'd3,
        ST_PROG1       = 3'd4,
        ST_PROG2       = 3'd5,
        ST_ERROR       = 3'd6
    } lock_state_t;
endpackage

// File: rtl/lock_enter_edge.sv
module lock_enter_edge (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic pulse
);
    logic btn_q;
    logic btn_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            btn_q    <= 1'b0;
            btn_prev <= 1'b0;
        end else begin
            btn_q    <= btn;
            btn_prev <= btn_q;
        end
    end

    assign pulse = btn_q & ~btn_prev;
endmodule

// File: rtl/lock_code_store.sv
module lock_code_store #(
    parameter int DIGIT_W = 2,
    parameter logic [DIGIT_W-1:0] DEF_FIRST  = 2'b11,
    parameter logic [DIGIT_W-1:0] DEF_SECOND = 2'b01
) (
    input  logic               clk,
    input  logic               load_default,
    input  logic               wr_first,
    input  logic               wr_second,
    input  logic [DIGIT_W-1:0] wr_data,
    output logic [DIGIT_W-1:0] first_digit,
    output logic [DIGIT_W-1:0] second_digit
);
    always_ff @(posedge clk) begin
        if (load_default) begin
            first_digit  <= DEF_FIRST;
            second_digit <= DEF_SECOND;
        end else begin
            if (wr_first)  first_digit  <= wr_data;
            if (wr_second) second_digit <= wr_data;
        end
    end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
#(
    parameter int DIGIT_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [DIGIT_W-1:0] code,
    input  logic [DIGIT_W-1:0] first_digit,
    input  logic [DIGIT_W-1:0] second_digit,
    output logic               wr_first,
    output logic               wr_second,
    output lock_state_t        state,
    output logic               is_open,
    output logic               is_prog1,
    output logic               is_prog2,
    output logic               is_error
);
    lock_state_t next_state;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT_D1;
        else     state <= next_state;
    end

    always_comb begin
        next_state = state;
        wr_first   = 1'b0;
        wr_second  = 1'b0;
        if (step) begin
            unique case (state)
                ST_WAIT_D1:     next_state = (code == first_digit)  ? ST_WAIT_D2 : ST_WAIT_D2_BAD;
                ST_WAIT_D2:     next_state = (code == second_digit) ? ST_OPEN    : ST_ERROR;
                ST_WAIT_D2_BAD: next_state = ST_ERROR;
                ST_OPEN:        next_state = ST_PROG1;
                ST_PROG1: begin
                    wr_first   = 1'b1;
                    next_state = ST_PROG2;
                end
                ST_PROG2: begin
                    wr_second  = 1'b1;
                    next_state = ST_OPEN;
                end
                ST_ERROR:       next_state = ST_WAIT_D1;
                default:        next_state = ST_WAIT_D1;
            endcase
        end
    end

    always_comb begin
        is_open  = 1'b0;
        is_prog1 = 1'b0;
        is_prog2 = 1'b0;
        is_error = 1'b0;
        unique case (state)
            ST_OPEN:  is_open  = 1'b1;
            ST_PROG1: is_prog1 = 1'b1;
            ST_PROG2: is_prog2 = 1'b1;
            ST_ERROR: is_error = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import lock_pkg::*;
#(
    parameter int DIGIT_W = 2,
    parameter logic [DIGIT_W-1:0] DEF_FIRST  = 2'b11,
    parameter logic [DIGIT_W-1:0] DEF_SECOND = 2'b01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIGIT_W-1:0] code_in,
    input  logic               enter_btn,
    input  logic               combo_reset,
    output logic               open_o,
    output logic               led_open,
    output logic               led_prog1,
    output logic               led_prog2,
    output logic               led_error,
    output logic [2:0]         state_dbg
);
    logic               enter_pulse;
    logic               wr_first;
    logic               wr_second;
    logic [DIGIT_W-1:0] first_digit;
    logic [DIGIT_W-1:0] second_digit;
    lock_state_t        cur_state;
    logic               is_open;

    lock_enter_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .btn   (enter_btn),
        .pulse (enter_pulse)
    );

    lock_code_store #(
        .DIGIT_W    (DIGIT_W),
        .DEF_FIRST  (DEF_FIRST),
        .DEF_SECOND (DEF_SECOND)
    ) u_store (
        .clk          (clk),
        .load_default (combo_reset),
        .wr_first     (wr_first),
        .wr_second    (wr_second),
        .wr_data      (code_in),
        .first_digit  (first_digit),
        .second_digit (second_digit)
    );

    lock_fsm #(.DIGIT_W(DIGIT_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .step         (enter_pulse),
        .code         (code_in),
        .first_digit  (first_digit),
        .second_digit (second_digit),
        .wr_first     (wr_first),
        .wr_second    (wr_second),
        .state        (cur_state),
        .is_open      (is_open),
        .is_prog1     (led_prog1),
        .is_prog2     (led_prog2),
        .is_error     (led_error)
    );

    assign open_o    = is_open;
    assign led_open  = is_open;
    assign state_dbg = cur_state;
endmodule

// File: rtl/combo_lock_checker.sv
module combo_lock_checker (
    input logic       clk,
    input logic       rst,
    input logic       enter_pulse,
    input logic       open_o,
    input logic       led_prog1,
    input logic       led_prog2,
    input logic       led_error,
    input logic       led_open,
    input logic [2:0] state_dbg
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state_dbg == 3'd0 && !open_o && !led_error));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        enter_pulse |=> !enter_pulse);

    a_r11_still_without_enter: assert property (@(posedge clk) disable iff (rst)
        !enter_pulse |=> $stable(state_dbg));

    a_r4_open_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> ($past(state_dbg) == 3'd1 || $past(state_dbg) == 3'd5));

    a_r5_error_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(led_error) |-> ($past(state_dbg) == 3'd1 || $past(state_dbg) == 3'd2));

    a_r8_prog_closed: assert property (@(posedge clk) disable iff (rst)
        (led_prog1 || led_prog2) |-> !open_o);

    a_r11_onehot_leds: assert property (@(posedge clk) disable iff (rst)
        $onehot0({led_open, led_prog1, led_prog2, led_error}));
endmodule

bind combo_lock combo_lock_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .enter_pulse (enter_pulse),
    .open_o      (open_o),
    .led_prog1   (led_prog1),
    .led_prog2   (led_prog2),
    .led_error   (led_error),
    .led_open    (led_open),
    .state_dbg   (state_dbg)
);

// File: tb/combo_lock_test.sv
`timescale 1ns/1ps
module combo_lock_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] code_in = 2'b00;
    logic       enter_btn = 1'b0;
    logic       combo_reset = 1'b0;
    logic       open_o, led_open, led_prog1, led_prog2, led_error;
    logic [2:0] state_dbg;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int         m_state = 0;
    logic [1:0] m_first = 2'b11;
    logic [1:0] m_second = 2'b01;

    always #2.5 clk = ~clk;

    combo_lock uut (
        .clk(clk), .rst(rst), .code_in(code_in), .enter_btn(enter_btn),
        .combo_reset(combo_reset), .open_o(open_o), .led_open(led_open),
        .led_prog1(led_prog1), .led_prog2(led_prog2), .led_error(led_error),
        .state_dbg(state_dbg)
    );

    function automatic int next_of(int s, logic [1:0] c, logic [1:0] f, logic [1:0] g);
        case (s)
            0: return (c == f) ? 1 : 2;
            1: return (c == g) ? 3 : 6;
            2: return 6;
            3: return 4;
            4: return 5;
            5: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " state"}, state_dbg, m_state);
        check({req, " open"}, open_o, m_state == 3);
        check({req, " led_open"}, led_open, m_state == 3);
        check({req, " prog1"}, led_prog1, m_state == 4);
        check({req, " prog2"}, led_prog2, m_state == 5);
        check({req, " error"}, led_error, m_state == 6);
    endtask

    task automatic press(logic [1:0] c, int hold);
        @(negedge clk);
        code_in = c;
        enter_btn = 1'b1;
        repeat (hold) @(negedge clk);
        enter_btn = 1'b0;
        repeat (4) @(negedge clk);
        if (m_state == 4) m_first = c;
        if (m_state == 5) m_second = c;
        m_state = next_of(m_state, c, m_first, m_second);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_state = 0;
        @(negedge clk);
    endtask

    task automatic do_combo_reset();
        @(negedge clk);
        combo_reset = 1'b1;
        @(negedge clk);
        combo_reset = 1'b0;
        m_first = 2'b11;
        m_second = 2'b01;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        combo_reset = 1'b1;
        repeat (3) @(negedge clk);
        combo_reset = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");
        check("R10 idle code", state_dbg, 0);

        // R4 default pair opens
        press(2'b11, 2); check("R4 first ok", state_dbg, 1);
        press(2'b01, 2); check_all("R4 open");
        check("R4 open_o", open_o, 1);
        // R8 / R9 programming to 00,10
        press(2'b11, 2); check_all("R8 prog1");
        check("R8 open low", open_o, 0);
        press(2'b00, 2); check_all("R9 prog2");
        press(2'b10, 2); check_all("R9 back open");
        do_reset();
        check_all("R1 reset keeps");
        press(2'b11, 2); press(2'b01, 2); check_all("R9 old pair fails");
        check("R9 old pair error", led_error, 1);
        press(2'b00, 2); check_all("R7 error clears");
        press(2'b00, 2); press(2'b10, 2); check_all("R9 new pair opens");
        check("R9 open", open_o, 1);
        // R5 wrong first digit hides error
        do_reset();
        press(2'b01, 2); check_all("R5 no early error");
        check("R5 error low", led_error, 0);
        press(2'b10, 2); check_all("R5 error after second");
        press(2'b00, 2);
        // R6 right first wrong second
        press(2'b00, 2); press(2'b11, 2); check_all("R6 wrong second");
        press(2'b00, 2);
        // R2 default reload
        do_combo_reset();
        press(2'b11, 2); press(2'b01, 2); check_all("R2 default restored");
        check("R2 open", open_o, 1);
        // R3 long hold
        press(2'b00, 30); check_all("R3 long hold one step");
        check("R3 state prog1", state_dbg, 4);
        // R11 code change without enter
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            code_in = 2'(k);
            repeat (3) @(negedge clk);
            check_all("R11 no enter");
        end
        // R2 priority over programming write in same cycle
        @(negedge clk);
        code_in = 2'b00;
        enter_btn = 1'b1;
        @(negedge clk);
        combo_reset = 1'b1;
        @(negedge clk);
        combo_reset = 1'b0;
        enter_btn = 1'b0;
        repeat (4) @(negedge clk);
        m_state = 5;
        m_first = 2'b11;
        m_second = 2'b01;
        check_all("R2 priority");
        press(2'b01, 2);
        do_reset();
        press(2'b11, 2); press(2'b01, 2); check_all("R2 priority pair");

        // random phase
        do_reset();
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom_range(0, 99));
            logic [1:0] c;
            if (r < 3) begin
                do_reset();
                check_all("R1 random reset");
            end else if (r < 6) begin
                do_combo_reset();
                check_all("R2 random reload");
            end else begin
                c = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 1) == 1) begin
                    if (m_state == 0) c = m_first;
                    if (m_state == 1) c = m_second;
                end
                press(c, int'($urandom_range(1, 6)));
                check_all("R4 R5 R6 R7 R8 R9 random");
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule